// File: doc/BRIEF.md
# Streaming Top-K Selection Memory

This block ranks a stream of signed scores on the fly and keeps only the best K of them, each paired with an arrival index that the block counts itself. A producer presents one score per cycle. The block holds a single threshold per list: the current worst kept entry and the slot it sits in. A score is compared only against that threshold. A score that loses is dropped at once. A score that wins overwrites the threshold slot. A shared scanner then walks that list to find the new worst entry and reloads the threshold, and the producer is held off while it does so.

The ranking direction (keep the largest or keep the smallest) and the list organisation are set when a batch starts. In single-list mode every score belongs to one ranking. In multi-list mode a list selector carries each score to one of NQ independent rankings, each with its own index counter. Starting a batch sets every slot to a sentinel that no real score can tie. When the stream ends, a reduction stage unloads the (score, index) pairs through a read port. The pairs come out in slot order and are not sorted.

Top module: `topk_select_mem`

## Requirements
- R1: After reset, and after every batch start, `in_stall` is high for exactly NQ*K cycles while the lists are initialised. Every slot then reads the sentinel with index 0, the threshold of every list is at slot 0, and the filled slots are taken in ascending order. The sentinel is -2^(DATA_W-1) when keeping the largest and 2^(DATA_W-1)-1 when keeping the smallest.
- R2: A score is accepted on a cycle with `in_valid` high and `in_stall` low. It is stored only if it is strictly better than its list's threshold. A score that ties the threshold, or is worse, leaves the stored contents unchanged.
- R3: The cycle after an accepted score is stored, `in_stall` rises and stays high for exactly K+1 cycles. A discarded score causes no stall.
- R4: Each list counts its accepted scores from 0, starting at the batch start. A score's index is that count, whether the score is stored or not.
- R5: With `cfg_low`=0, after any stream each list holds the K largest scores. Among equal scores the earlier arrival (lower index) is kept. When several kept entries are equally worst, the later arrival is the one evicted next.
- R6: With `cfg_low`=1 the same holds for the K smallest scores.
- R7: With `cfg_multi`=1, `in_list` selects the list and the lists rank independently. With `cfg_multi`=0, `in_list` is ignored and every score goes to list 0.
- R8: A read request with `rd_en` returns the score and index of slot {`rd_list`,`rd_slot`} with `rd_valid` high in the following cycle. `rd_valid` is low in the cycle after a cycle with no request.
- R9: `cfg_multi` and `cfg_low` take effect only at a batch start. A batch start during a scan aborts the scan and re-initialises all lists and counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| batch_start | input | 1 | Begin a new ranking batch; captures the configuration |
| cfg_multi | input | 1 | 1: NQ separate lists, 0: one list |
| cfg_low | input | 1 | 1: keep smallest scores, 0: keep largest |
| in_valid | input | 1 | Score present |
| in_val | input | DATA_W | Signed score |
| in_list | input | log2(NQ) | Target list in multi-list mode |
| in_stall | output | 1 | Producer must hold its score |
| rd_en | input | 1 | Read request |
| rd_list | input | log2(NQ) | List to read |
| rd_slot | input | log2(K) | Slot to read |
| rd_valid | output | 1 | Read data valid (one cycle after request) |
| rd_val | output | DATA_W | Stored score |
| rd_idx | output | IDX_W | Stored arrival index |

## Verification
A wrong threshold shows up quickly, as a stall pattern that disagrees with the expected insert-or-discard decision, visible on `in_stall` one cycle after the next accepted score. An error in the scanner's choice of worst entry, including the tie-break on arrival order, stays hidden until the list is unloaded. At that point a score or index that is missing from the reference top-K set shows on the read port. Index-counter faults appear in `rd_idx` at read-out, and initialisation faults appear as wrong stall lengths or as non-sentinel slots right after a batch start.

// File: rtl/topk_pkg.sv
// Shared types for the streaming top-K selection memory.
package topk_pkg;

    // Ranking direction: which end of the value range is kept.
    typedef enum logic {
        RANK_HIGH = 1'b0,
        RANK_LOW  = 1'b1
    } rank_dir_e;

endpackage

// File: rtl/topk_store.sv
// Entry storage for all lists: one write port, one combinational scan read
// port for the scanner, and one registered read port (one-cycle latency)
// for the reduction stage. Assumes writers never collide (the top arbitrates).
module topk_store #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 12,
    parameter int DEPTH  = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_val,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] scan_addr,
    output logic [DATA_W-1:0] scan_val,
    output logic [IDX_W-1:0]  scan_idx,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_val,
    output logic [IDX_W-1:0]  rd_idx
);

    logic [DATA_W-1:0] val_mem [DEPTH];
    logic [IDX_W-1:0]  idx_mem [DEPTH];

    // Write port: one entry per cycle.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            val_mem[wr_addr] <= wr_val;
            idx_mem[wr_addr] <= wr_idx;
        end
    end

    // Scan port: combinational read for the scanner.
    always_comb begin
        scan_val = val_mem[scan_addr];
        scan_idx = idx_mem[scan_addr];
    end

    // Unload port valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= rd_en;
    end

    // Unload port data register.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_val <= val_mem[rd_addr];
            rd_idx <= idx_mem[rd_addr];
        end
    end

endmodule

// File: rtl/topk_filter_bank.sv
// Per-list threshold filter: holds the worst kept value of each list and its
// slot, and decides whether an incoming value is strictly better than it.
// Assumes init_load is held for the whole initialisation walk.
module topk_filter_bank
    import topk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NQ     = 4,
    parameter int K      = 8,
    localparam int LIST_W = $clog2(NQ),
    localparam int SLOT_W = $clog2(K)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init_load,
    input  logic [DATA_W-1:0]    sentinel,
    input  logic                 upd_en,
    input  logic [LIST_W-1:0]    upd_list,
    input  logic [DATA_W-1:0]    upd_val,
    input  logic [SLOT_W-1:0]    upd_slot,
    input  rank_dir_e            dir,
    input  logic [LIST_W-1:0]    q_list,
    input  logic [DATA_W-1:0]    q_val,
    output logic                 q_pass,
    output logic [SLOT_W-1:0]    q_slot,
    output logic [NQ*DATA_W-1:0] thr_flat
);

    logic [NQ*SLOT_W-1:0] slot_flat;
    logic [DATA_W-1:0]    thr_sel;

    for (genvar g = 0; g < NQ; g++) begin : g_list
        logic [DATA_W-1:0] val_q;
        logic [SLOT_W-1:0] slot_q;

        // Threshold register of one list: initialise, or take the scanner result.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q  <= {1'b1, {(DATA_W-1){1'b0}}};
                slot_q <= '0;
            end else if (init_load) begin
                val_q  <= sentinel;
                slot_q <= '0;
            end else if (upd_en && upd_list == LIST_W'(g)) begin
                val_q  <= upd_val;
                slot_q <= upd_slot;
            end
        end

        assign thr_flat[g*DATA_W +: DATA_W]  = val_q;
        assign slot_flat[g*SLOT_W +: SLOT_W] = slot_q;
    end

    // Strict comparison against the selected list's threshold; ties fail.
    always_comb begin
        thr_sel = thr_flat[q_list*DATA_W +: DATA_W];
        q_slot  = slot_flat[q_list*SLOT_W +: SLOT_W];
        if (dir == RANK_HIGH) q_pass = $signed(q_val) > $signed(thr_sel);
        else                  q_pass = $signed(q_val) < $signed(thr_sel);
    end

endmodule

// File: rtl/topk_scanner.sv
// Walks the K slots of one list, one per cycle, and finds the worst entry:
// worst value first, then later arrival (higher index), then lowest slot.
// Reports the result on the last scan cycle. Assumes start is never raised
// while busy; abort has priority over everything.
module topk_scanner
    import topk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 12,
    parameter int K      = 8,
    parameter int NQ     = 4,
    localparam int LIST_W = $clog2(NQ),
    localparam int SLOT_W = $clog2(K),
    localparam int ADDR_W = LIST_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  logic [LIST_W-1:0] start_list,
    input  rank_dir_e         dir,
    output logic [ADDR_W-1:0] scan_addr,
    input  logic [DATA_W-1:0] scan_val,
    input  logic [IDX_W-1:0]  scan_idx,
    output logic              busy,
    output logic              upd_en,
    output logic [LIST_W-1:0] upd_list,
    output logic [DATA_W-1:0] upd_val,
    output logic [SLOT_W-1:0] upd_slot
);

    logic [SLOT_W-1:0] ptr_q;
    logic [LIST_W-1:0] list_q;
    logic [DATA_W-1:0] best_val_q;
    logic [IDX_W-1:0]  best_idx_q;
    logic [SLOT_W-1:0] best_slot_q;
    logic              entry_worse;
    logic              take;
    logic              last;
    logic [DATA_W-1:0] cand_val;
    logic [IDX_W-1:0]  cand_idx;
    logic [SLOT_W-1:0] cand_slot;

    // Compare the slot under the pointer with the worst entry found so far.
    always_comb begin
        if (dir == RANK_HIGH)
            entry_worse = ($signed(scan_val) < $signed(best_val_q)) ||
                          (scan_val == best_val_q && scan_idx > best_idx_q);
        else
            entry_worse = ($signed(scan_val) > $signed(best_val_q)) ||
                          (scan_val == best_val_q && scan_idx > best_idx_q);
        take      = (ptr_q == '0) || entry_worse;
        cand_val  = take ? scan_val : best_val_q;
        cand_idx  = take ? scan_idx : best_idx_q;
        cand_slot = take ? ptr_q    : best_slot_q;
        last      = (ptr_q == SLOT_W'(K-1));
    end

    assign scan_addr = {list_q, ptr_q};
    assign upd_en    = busy && last;
    assign upd_list  = list_q;
    assign upd_val   = cand_val;
    assign upd_slot  = cand_slot;

    // Scan sequencing and running worst-entry registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            ptr_q       <= '0;
            list_q      <= '0;
            best_val_q  <= '0;
            best_idx_q  <= '0;
            best_slot_q <= '0;
        end else if (abort) begin
            busy  <= 1'b0;
            ptr_q <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            ptr_q  <= '0;
            list_q <= start_list;
        end else if (busy) begin
            best_val_q  <= cand_val;
            best_idx_q  <= cand_idx;
            best_slot_q <= cand_slot;
            ptr_q       <= ptr_q + SLOT_W'(1);
            if (last) busy <= 1'b0;
        end
    end

endmodule

// File: rtl/topk_select_mem.sv
// Streaming top-K selection memory. Scores pass a per-list threshold filter;
// a winner overwrites the threshold slot one cycle after acceptance, then a
// K-cycle scan reloads the threshold while in_stall holds the producer.
// Assumes K and NQ are powers of two, both at least 2.
module topk_select_mem
    import topk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 12,
    parameter int K      = 8,
    parameter int NQ     = 4,
    localparam int LIST_W = $clog2(NQ),
    localparam int SLOT_W = $clog2(K)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              batch_start,
    input  logic              cfg_multi,
    input  logic              cfg_low,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_val,
    input  logic [LIST_W-1:0] in_list,
    output logic              in_stall,
    input  logic              rd_en,
    input  logic [LIST_W-1:0] rd_list,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_val,
    output logic [IDX_W-1:0]  rd_idx
);

    localparam int ADDR_W = LIST_W + SLOT_W;
    localparam int DEPTH  = NQ * K;

    logic                 multi_q;
    rank_dir_e            dir_q;
    logic [DATA_W-1:0]    sentinel;
    logic                 init_busy;
    logic [ADDR_W-1:0]    init_ptr;
    logic [LIST_W-1:0]    eff_list;
    logic                 accept;
    logic                 f_pass;
    logic [SLOT_W-1:0]    f_slot;
    logic [NQ*DATA_W-1:0] thr_flat;
    logic [NQ*IDX_W-1:0]  cnt_flat;
    logic [IDX_W-1:0]     cur_idx;
    logic                 stg_pass;
    logic [LIST_W-1:0]    stg_list;
    logic [SLOT_W-1:0]    stg_slot;
    logic [DATA_W-1:0]    stg_val;
    logic [IDX_W-1:0]     stg_idx;
    logic                 wr_en;
    logic [ADDR_W-1:0]    wr_addr;
    logic [DATA_W-1:0]    wr_val;
    logic [IDX_W-1:0]     wr_idx;
    logic [ADDR_W-1:0]    scan_addr;
    logic [DATA_W-1:0]    scan_val;
    logic [IDX_W-1:0]     scan_idx;
    logic                 scan_busy;
    logic                 upd_en;
    logic [LIST_W-1:0]    upd_list;
    logic [DATA_W-1:0]    upd_val;
    logic [SLOT_W-1:0]    upd_slot;

    // Configuration capture at batch start only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            multi_q <= 1'b0;
            dir_q   <= RANK_HIGH;
        end else if (batch_start) begin
            multi_q <= cfg_multi;
            dir_q   <= cfg_low ? RANK_LOW : RANK_HIGH;
        end
    end

    assign sentinel = (dir_q == RANK_LOW) ? {1'b0, {(DATA_W-1){1'b1}}}
                                          : {1'b1, {(DATA_W-1){1'b0}}};

    // Initialisation walk over every slot of every list.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_busy <= 1'b1;
            init_ptr  <= '0;
        end else if (batch_start) begin
            init_busy <= 1'b1;
            init_ptr  <= '0;
        end else if (init_busy) begin
            init_ptr <= init_ptr + ADDR_W'(1);
            if (init_ptr == ADDR_W'(DEPTH-1)) init_busy <= 1'b0;
        end
    end

    assign in_stall = init_busy | stg_pass | scan_busy;
    assign eff_list = multi_q ? in_list : '0;
    assign accept   = in_valid && !in_stall && !batch_start;

    // Per-list arrival counters that generate the document indexes.
    for (genvar g = 0; g < NQ; g++) begin : g_cnt
        logic [IDX_W-1:0] cnt_q;

        // Count accepted scores of this list; cleared at reset and batch start.
        always_ff @(posedge clk) begin
            if (!rst_n || batch_start)                    cnt_q <= '0;
            else if (accept && eff_list == LIST_W'(g))    cnt_q <= cnt_q + IDX_W'(1);
        end

        assign cnt_flat[g*IDX_W +: IDX_W] = cnt_q;
    end

    assign cur_idx = cnt_flat[eff_list*IDX_W +: IDX_W];

    topk_filter_bank #(
        .DATA_W (DATA_W),
        .NQ     (NQ),
        .K      (K)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_load (init_busy),
        .sentinel  (sentinel),
        .upd_en    (upd_en),
        .upd_list  (upd_list),
        .upd_val   (upd_val),
        .upd_slot  (upd_slot),
        .dir       (dir_q),
        .q_list    (eff_list),
        .q_val     (in_val),
        .q_pass    (f_pass),
        .q_slot    (f_slot),
        .thr_flat  (thr_flat)
    );

    // Insert stage: holds a winning score for the write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || batch_start) begin
            stg_pass <= 1'b0;
            stg_list <= '0;
            stg_slot <= '0;
            stg_val  <= '0;
            stg_idx  <= '0;
        end else begin
            stg_pass <= accept && f_pass;
            if (accept) begin
                stg_list <= eff_list;
                stg_slot <= f_slot;
                stg_val  <= in_val;
                stg_idx  <= cur_idx;
            end
        end
    end

    // Store write arbitration: the initialisation walk has priority.
    always_comb begin
        wr_en   = init_busy | stg_pass;
        wr_addr = init_busy ? init_ptr : {stg_list, stg_slot};
        wr_val  = init_busy ? sentinel : stg_val;
        wr_idx  = init_busy ? '0       : stg_idx;
    end

    topk_store #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_val    (wr_val),
        .wr_idx    (wr_idx),
        .scan_addr (scan_addr),
        .scan_val  (scan_val),
        .scan_idx  (scan_idx),
        .rd_en     (rd_en),
        .rd_addr   ({rd_list, rd_slot}),
        .rd_valid  (rd_valid),
        .rd_val    (rd_val),
        .rd_idx    (rd_idx)
    );

    topk_scanner #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .K      (K),
        .NQ     (NQ)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (batch_start),
        .start      (stg_pass),
        .start_list (stg_list),
        .dir        (dir_q),
        .scan_addr  (scan_addr),
        .scan_val   (scan_val),
        .scan_idx   (scan_idx),
        .busy       (scan_busy),
        .upd_en     (upd_en),
        .upd_list   (upd_list),
        .upd_val    (upd_val),
        .upd_slot   (upd_slot)
    );

endmodule

// File: rtl/topk_select_mem_chk.sv
// Assertion checker for topk_select_mem, attached by bind below.
// Assumes the producer never holds batch_start high for long stretches.
module topk_select_mem_chk #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 12,
    parameter int K      = 8,
    parameter int NQ     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 batch_start,
    input logic                 in_stall,
    input logic                 rd_en,
    input logic                 rd_valid,
    input logic                 init_busy,
    input logic                 dir_low,
    input logic [NQ*IDX_W-1:0]  cnt_flat,
    input logic [NQ*DATA_W-1:0] thr_flat
);

    localparam int RUN_LIMIT = NQ * K + K + 1;

    logic [15:0] stall_run;

    // Length of the current unbroken stall stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)        stall_run <= '0;
        else if (in_stall) stall_run <= stall_run + 16'd1;
        else               stall_run <= '0;
    end

    p_init_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        batch_start |=> in_stall);

    p_hold_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stall && !batch_start) |=> $stable(cnt_flat));

    p_stall_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stall_run <= 16'(RUN_LIMIT));

    p_rd_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_rd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    for (genvar g = 0; g < NQ; g++) begin : g_thr
        // R5: keeping the largest, a list threshold never drops within a batch.
        p_thr_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!init_busy && !batch_start && !dir_low) |=>
            $signed(thr_flat[g*DATA_W +: DATA_W]) >= $signed($past(thr_flat[g*DATA_W +: DATA_W])));

        // R6: keeping the smallest, a list threshold never rises within a batch.
        p_thr_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!init_busy && !batch_start && dir_low) |=>
            $signed(thr_flat[g*DATA_W +: DATA_W]) <= $signed($past(thr_flat[g*DATA_W +: DATA_W])));
    end

endmodule

bind topk_select_mem topk_select_mem_chk #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .K      (K),
    .NQ     (NQ)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .batch_start (batch_start),
    .in_stall    (in_stall),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid),
    .init_busy   (init_busy),
    .dir_low     (dir_q == topk_pkg::RANK_LOW),
    .cnt_flat    (cnt_flat),
    .thr_flat    (thr_flat)
);

// File: tb/topk_select_mem_test.sv
`timescale 1ns/1ps
module topk_select_mem_test;

    localparam int DATA_W = 16;
    localparam int IDX_W  = 12;
    localparam int K      = 8;
    localparam int NQ     = 4;
    localparam int LIST_W = $clog2(NQ);
    localparam int SLOT_W = $clog2(K);
    localparam int DEPTH  = NQ * K;
    localparam int MAXN   = 600;
    localparam int TBL_N  = 18;
    // Directed stream for one list keeping the largest: {score, expected insert}.
    localparam int TBL [TBL_N][2] = '{
        '{10, 1}, '{-5, 1}, '{30, 1}, '{7, 1}, '{7, 1}, '{0, 1},
        '{100, 1}, '{-20, 1}, '{-20, 0}, '{-21, 0}, '{-19, 1}, '{-19, 0},
        '{-5, 1}, '{-5, 0}, '{1, 1}, '{2, 1}, '{0, 0}, '{50, 1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              batch_start = 1'b0;
    logic              cfg_multi = 1'b0;
    logic              cfg_low = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_val = '0;
    logic [LIST_W-1:0] in_list = '0;
    logic              in_stall;
    logic              rd_en = 1'b0;
    logic [LIST_W-1:0] rd_list = '0;
    logic [SLOT_W-1:0] rd_slot = '0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_val;
    logic [IDX_W-1:0]  rd_idx;

    int total = 0;
    int fails = 0;
    bit cur_multi = 0;
    bit cur_low = 0;
    int arr_val [NQ][MAXN];
    int arr_cnt [NQ];

    always #2 clk = ~clk;

    topk_select_mem #(
        .DATA_W (DATA_W), .IDX_W (IDX_W), .K (K), .NQ (NQ)
    ) uut (
        .clk (clk), .rst_n (rst_n), .batch_start (batch_start),
        .cfg_multi (cfg_multi), .cfg_low (cfg_low),
        .in_valid (in_valid), .in_val (in_val), .in_list (in_list),
        .in_stall (in_stall), .rd_en (rd_en), .rd_list (rd_list),
        .rd_slot (rd_slot), .rd_valid (rd_valid), .rd_val (rd_val),
        .rd_idx (rd_idx)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sentinel(input bit low);
        return low ? 32767 : -32768;
    endfunction

    // Count stall cycles from the current negedge until the stall clears.
    task automatic count_stall(output int n);
        n = 0;
        while (in_stall) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic start_batch(input bit multi, input bit low, output int n);
        @(negedge clk);
        batch_start = 1'b1;
        cfg_multi   = multi;
        cfg_low     = low;
        @(negedge clk);
        batch_start = 1'b0;
        cur_multi   = multi;
        cur_low     = low;
        for (int q = 0; q < NQ; q++) arr_cnt[q] = 0;
        count_stall(n);
    endtask

    // Present one score, wait for acceptance, report insert and stall length.
    task automatic push(input int v, input int l, output bit ins, output int slen);
        int e;
        @(negedge clk);
        in_valid = 1'b1;
        in_val   = DATA_W'(v);
        in_list  = LIST_W'(l);
        while (in_stall) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        e = cur_multi ? l : 0;
        arr_val[e][arr_cnt[e]] = v;
        arr_cnt[e]++;
        ins = in_stall;
        count_stall(slen);
    endtask

    task automatic read_slot(input int l, input int s, output int v, output int i,
                             output bit vld);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_list = LIST_W'(l);
        rd_slot = SLOT_W'(s);
        @(negedge clk);
        rd_en = 1'b0;
        v   = int'($signed(rd_val));
        i   = int'(rd_idx);
        vld = rd_valid;
    endtask

    // Compare a list with the reference best-K set (earlier arrival wins ties).
    task automatic check_list(input int q, input string req);
        int ev [K];
        int ei [K];
        bit taken [K];
        bit used [MAXN];
        for (int a = 0; a < MAXN; a++) used[a] = 0;
        for (int s = 0; s < K; s++) begin
            int best = -1;
            for (int a = 0; a < arr_cnt[q]; a++) begin
                if (!used[a]) begin
                    if (best < 0) best = a;
                    else if (cur_low ? (arr_val[q][a] < arr_val[q][best])
                                     : (arr_val[q][a] > arr_val[q][best])) best = a;
                end
            end
            taken[s] = 0;
            if (best >= 0) begin
                used[best] = 1;
                ev[s] = arr_val[q][best];
                ei[s] = best;
            end else begin
                ev[s] = sentinel(cur_low);
                ei[s] = 0;
            end
        end
        for (int s = 0; s < K; s++) begin
            int v, i, hit;
            bit vld;
            read_slot(q, s, v, i, vld);
            hit = -1;
            for (int t = 0; t < K; t++)
                if (hit < 0 && !taken[t] && ev[t] == v && ei[t] == i) hit = t;
            if (hit >= 0) taken[hit] = 1;
            check(hit >= 0, req, $sformatf("list %0d slot %0d pair (value, index %0d) not in best set; value",
                  q, s, i), v, (hit >= 0) ? v : ev[s]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int n, v, i, slen;
        bit ins, vld;

        // Reset: initialisation stall and sentinel contents (R1), read timing (R8).
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int q = 0; q < NQ; q++) arr_cnt[q] = 0;
        count_stall(n);
        check(n == DEPTH, "R1", "init stall cycles after reset", n, DEPTH);
        read_slot(2, 5, v, i, vld);
        check(v == -32768, "R1", "slot value after reset", v, -32768);
        check(i == 0, "R1", "slot index after reset", i, 0);
        check(vld == 1'b1, "R8", "rd_valid one cycle after request", int'(vld), 1);
        @(negedge clk);
        check(rd_valid == 1'b0, "R8", "rd_valid with no request", int'(rd_valid), 0);

        // Table walk: insert-or-discard decision and stall length per score.
        for (int t = 0; t < TBL_N; t++) begin
            push(TBL[t][0], 0, ins, slen);
            check(int'(ins) == TBL[t][1], "R2", $sformatf("insert flag for entry %0d", t),
                  int'(ins), TBL[t][1]);
            check(slen == (TBL[t][1] != 0 ? K + 1 : 0), "R3",
                  $sformatf("stall length for entry %0d", t), slen,
                  TBL[t][1] != 0 ? K + 1 : 0);
        end
        read_slot(0, 5, v, i, vld);
        check(v == 50, "R4", "value in slot 5", v, 50);
        check(i == 17, "R4", "arrival index in slot 5", i, 17);
        check_list(0, "R5");

        // Smallest mode, single list; in_list must be ignored (R7, R9).
        start_batch(1'b0, 1'b1, n);
        check(n == DEPTH, "R1", "init stall cycles after batch start", n, DEPTH);
        read_slot(0, 3, v, i, vld);
        check(v == 32767, "R9", "sentinel after switching to smallest", v, 32767);
        for (int t = 0; t < 150; t++) push($urandom_range(80) - 40, $urandom_range(NQ - 1), ins, slen);
        check(arr_cnt[0] == 150, "R7", "scores routed to list 0", arr_cnt[0], 150);
        check_list(0, "R6");
        check_list(1, "R7");

        // Multi-list mode, largest kept, narrow value range for ties.
        start_batch(1'b1, 1'b0, n);
        for (int t = 0; t < 300; t++) push($urandom_range(60) - 30, $urandom_range(NQ - 1), ins, slen);
        for (int q = 0; q < NQ; q++) check_list(q, "R7");

        // Single list, largest kept, wide range.
        start_batch(1'b0, 1'b0, n);
        for (int t = 0; t < 200; t++) push($urandom_range(2000) - 1000, 0, ins, slen);
        check_list(0, "R5");

        // Batch start during a scan aborts it and re-initialises (R9).
        @(negedge clk);
        in_valid = 1'b1;
        in_val   = DATA_W'(5000);
        in_list  = '0;
        @(negedge clk);
        in_valid = 1'b0;
        check(in_stall == 1'b1, "R3", "stall after inserting score", int'(in_stall), 1);
        start_batch(1'b0, 1'b0, n);
        check(n == DEPTH, "R9", "init stall after mid-scan batch start", n, DEPTH);
        read_slot(0, 0, v, i, vld);
        check(v == -32768, "R9", "slot 0 re-initialised", v, -32768);
        push(3, 0, ins, slen);
        read_slot(0, 0, v, i, vld);
        check(v == 3, "R4", "first score after restart value", v, 3);
        check(i == 0, "R4", "first score after restart index", i, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule